// File: doc/BRIEF.md
# Serial Display Frame Receiver

This block takes a three-wire serial stream (data, shift clock, load strobe) from a host and turns it into display row contents and display configuration. Every frame carries 160 display bits followed by an 8-bit command byte. The command byte decides what the frame does. It can set the frame-rate selection or switch the display on or off. It can also write the 160 data bits into one of four common-row latches, but only when the chip address in the command matches this chip's strapped address. Several chips can therefore share one serial bus in a cascade.

All three serial pins are asynchronous to the system clock. Each is brought in through a two-flop synchroniser and edge-detected in the system clock domain. The system clock must run at least eight times faster than the serial clock. While load is high, the addressed row follows the shift register, so the latch is transparent. When load falls, the row keeps the last value.

Top module: `serial_frame_rx`

## Requirements
- R1: A bit is shifted into the 168-bit shift register on each rising edge of the synchronised serial clock. The frame is sent d1 first through d160, then command bits c0 through c7, so c7 is the last bit sent.
- R2: Written row data is reversed relative to the arrival order: row bit s (0-based, segment s+1) holds data bit d(160-s). Row bit 0 holds d160 and row bit 159 holds d1.
- R3: While load is high, the addressed row follows the shift register, including bits shifted in during that time. After load falls, the row holds its value no matter what is shifted in later.
- R4: A command with c7c6 = 00 changes nothing.
- R5: A command with c7c6 = 01 sets `rate_sel` to {c5,c4}.
- R6: A command with c7c6c5 = 101 sets `disp_on` to c4. A command with c7c6c5 = 100 changes nothing.
- R7: A command with c7c6 = 11 is a data write. It writes only when {c5,c4,c3,c2} equals {1, `addr_sa0`, `addr_a1`, `addr_a0`}. It writes row {c1,c0}. `addr_hit` shows whether the last command was a matching write, and `row_sel` shows its {c1,c0}.
- R8: A command that is not a matching write leaves all four rows unchanged.
- R9: The command taken is the one held in the shift register when load rises. Extra dummy bits sent before d1 have no effect.
- R10: After reset, `rate_sel` = 0, `disp_on` = 0, `addr_hit` = 0, `row_sel` = 0 and all rows are 0.
- R11: The effect of a load rise appears at the third rising system-clock edge at which the load pin is sampled high, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Load strobe (asynchronous) |
| addr_sa0 | input | 1 | Strapped chip address bit, compared with c4 |
| addr_a1 | input | 1 | Strapped chip address bit, compared with c3 |
| addr_a0 | input | 1 | Strapped chip address bit, compared with c2 |
| rate_sel | output | 2 | Frame-rate selection {f1,f0} |
| disp_on | output | 1 | Display enable flag |
| addr_hit | output | 1 | Last command was a write addressed to this chip |
| row_sel | output | 2 | Row field of the last command |
| rows_q | output | 640 | Four row latches; row r at bits [r*160 +: 160] |

## Verification
The bench drives frames that carry each command class. These are a rate set, display on and off, the ignored 00 and 100 codes, a matching write and a write with a wrong address. Each frame comes with a distinct data pattern, so a write can be told apart from a frame whose data should be ignored. A frame with only d1 set, and another with a non-symmetric pattern, separate correct bit reversal from straight or shifted mapping. A frame led by dummy bits shows that only the last 168 bits count. Bits shifted while load is still high, and bits shifted after it falls, separate transparent latching from holding. A behavioural cycle model, compared on every clock, pins down the three-edge latency.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int SEGS = 160,
  parameter int ROWS = 4,
  parameter int CMDW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 ser_load,
  input  logic                 addr_sa0,
  input  logic                 addr_a1,
  input  logic                 addr_a0,
  output logic [1:0]           rate_sel,
  output logic                 disp_on,
  output logic                 addr_hit,
  output logic [1:0]           row_sel,
  output logic [ROWS*SEGS-1:0] rows_q
);
  localparam int SRW = SEGS + CMDW;
  localparam int RSW = $clog2(ROWS);

  logic [2:0] ck_s, ld_s, dt_s;
  logic [SRW-1:0] sr;
  logic [CMDW-1:0] cmd_now, cmd_q, act;
  logic ck_rise, ld_rise, ld_lvl, is_wr, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0; ld_s <= '0; dt_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], ser_clk};
      ld_s <= {ld_s[1:0], ser_load};
      dt_s <= {dt_s[1:0], ser_dat};
    end

  assign ck_rise = ck_s[1] & ~ck_s[2];
  assign ld_rise = ld_s[1] & ~ld_s[2];
  assign ld_lvl  = ld_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (ck_rise) sr <= {sr[SRW-2:0], dt_s[1]};

  for (genvar i = 0; i < CMDW; i++) begin : g_cmd
    assign cmd_now[i] = sr[CMDW-1-i];
  end

  assign act   = ld_rise ? cmd_now : cmd_q;
  assign is_wr = act[7:6] == 2'b11;
  assign hit   = is_wr && (act[5:2] == {1'b1, addr_sa0, addr_a1, addr_a0});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q    <= '0;
      rate_sel <= '0;
      disp_on  <= 1'b0;
      addr_hit <= 1'b0;
      row_sel  <= '0;
    end else if (ld_rise) begin
      cmd_q    <= cmd_now;
      addr_hit <= hit;
      row_sel  <= cmd_now[1:0];
      if (cmd_now[7:6] == 2'b01) rate_sel <= cmd_now[5:4];
      if (cmd_now[7:5] == 3'b101) disp_on <= cmd_now[4];
    end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rows_q[r*SEGS +: SEGS] <= '0;
      else if (ld_lvl && hit && act[RSW-1:0] == RSW'(r))
        rows_q[r*SEGS +: SEGS] <= sr[SRW-1:CMDW];
  end

  // R5
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(rate_sel));
  // R6
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(disp_on));
  // R7
  rsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(row_sel));
  // R3
  row_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lvl |=> $stable(rows_q));
  // R8
  row_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_q != $past(rows_q)) |-> addr_hit);
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, ser_load = 0;
  logic sa0 = 1, a1 = 0, a0 = 1;
  logic [1:0] rate_sel, row_sel;
  logic disp_on, addr_hit;
  logic [639:0] rows_q;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  serial_frame_rx u_dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .addr_sa0(sa0), .addr_a1(a1), .addr_a0(a0), .rate_sel(rate_sel),
    .disp_on(disp_on), .addr_hit(addr_hit), .row_sel(row_sel), .rows_q(rows_q));

  // behavioural reference model
  logic [2:0] hist[$];
  logic [167:0] msr;
  logic [7:0] mcmd;
  logic [1:0] m_rate, m_rsel;
  logic m_disp, m_hit;
  logic [639:0] m_rows;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b000, 3'b000, 3'b000};
      msr = 0; mcmd = 0; m_rate = 0; m_rsel = 0; m_disp = 0; m_hit = 0; m_rows = 0;
    end else begin
      logic [2:0] now, prv;
      logic [7:0] c;
      logic wr_ok;
      hist.push_back({ser_clk, ser_load, ser_dat});
      if (hist.size() > 4) void'(hist.pop_front());
      now = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      c = mcmd;
      if (now[1] && !prv[1]) begin
        for (int i = 0; i < 8; i++) c[i] = msr[7-i];
        mcmd = c;
        if (c[7:6] == 2'd1) m_rate = c[5:4];
        if (c[7:5] == 3'd5) m_disp = c[4];
        m_rsel = c[1:0];
      end
      wr_ok = (c[7:6] == 2'd3) && (c[5:2] == {1'b1, sa0, a1, a0});
      if (now[1] && !prv[1]) m_hit = wr_ok;
      if (now[1] && wr_ok)
        for (int s = 0; s < 160; s++) m_rows[c[1:0]*160 + s] = msr[167 - (159 - s)];
      if (now[2] && !prv[2]) msr = {msr[166:0], now[0]};
    end
  end

  always @(negedge clk) if (rst_n) begin
    compared++;
    if ({rate_sel, disp_on, addr_hit, row_sel, rows_q} !== {m_rate, m_disp, m_hit, m_rsel, m_rows}) begin
      mismatched++;
      $display("FAIL R11 cycle model t=%0t act=%h/%b/%b/%h exp=%h/%b/%b/%h", $time,
               rate_sel, disp_on, addr_hit, row_sel, m_rate, m_disp, m_hit, m_rsel);
    end
  end

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [159:0] rev(input logic [159:0] d);
    logic [159:0] r;
    for (int s = 0; s < 160; s++) r[s] = d[159-s];
    return r;
  endfunction

  function automatic logic [159:0] row(input int r);
    return rows_q[r*160 +: 160];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b; ser_clk = 0;
    wait_cyc(4); ser_clk = 1;
    wait_cyc(4); ser_clk = 0;
  endtask

  task automatic send_body(input logic [159:0] d, input logic [7:0] cmd);
    for (int i = 0; i < 160; i++) send_bit(d[i]);   // d1 = d[0] first
    for (int i = 0; i < 8; i++) send_bit(cmd[i]);   // c0 first, c7 last
    wait_cyc(2);
  endtask

  task automatic pulse_load;
    ser_load = 1; wait_cyc(8); ser_load = 0; wait_cyc(8);
  endtask

  task automatic frame(input logic [159:0] d, input logic [7:0] cmd);
    send_body(d, cmd); pulse_load();
  endtask

  initial begin
    logic [159:0] pa, pb, pc, held;
    pa = {40{4'b1100}} ^ 160'h1;
    pb = {20{8'h5A}};
    pc = {80{2'b01}} | (160'h1 << 159);
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    // R10 reset state
    check("R10 rate", rate_sel, 0);
    check("R10 disp", disp_on, 0);
    check("R10 hit", addr_hit, 0);
    check("R10 rows", rows_q[159:0] | rows_q[319:160] | rows_q[479:320] | rows_q[639:480], 0);
    // R6 display on, 100 ignored, off
    frame(pb, 8'hB0); check("R6 on", disp_on, 1);
    frame(pb, 8'h90); check("R6 100 ignored", disp_on, 1);
    check("R8 display cmd no write", rows_q[159:0] | rows_q[319:160], 0);
    // R5 rate
    frame(pb, 8'h60); check("R5 rate", rate_sel, 2);
    // R4 ignored class
    frame(pb, 8'h3F); check("R4 rate kept", rate_sel, 2);
    check("R4 disp kept", disp_on, 1);
    // R7 matching write row 2, R2 reversal
    frame(pa, 8'hF6);
    check("R2 row2 reversed", row(2), rev(pa));
    check("R7 hit", addr_hit, 1);
    check("R7 row_sel", row_sel, 2);
    // R7 wrong address, row 1
    frame(pb, 8'hF1);
    check("R7 miss no write", row(1), 0);
    check("R7 miss hit", addr_hit, 0);
    check("R8 row2 kept", row(2), rev(pa));
    // R1 single d1 bit lands at row bit 159
    frame(160'h1, 8'hF4);
    check("R1 d1 order", row(0), 160'h1 << 159);
    // R9 dummy bits ahead of frame
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    frame(pc, 8'hF5);
    check("R9 dummy ignored", row(1), rev(pc));
    // R3 transparency then hold
    send_body(pb, 8'hF7);
    ser_load = 1; wait_cyc(8);
    check("R3 row3 written", row(3), rev(pb));
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    wait_cyc(4);
    held = row(3);
    check("R3 follows while high", (held != rev(pb)) ? 160'd1 : 160'd0, 1);
    ser_load = 0; wait_cyc(8);
    for (int i = 0; i < 30; i++) send_bit(i[0]);
    wait_cyc(4);
    check("R3 held after fall", row(3), held);
    // R11 latency
    send_body(pb, 8'hA0);
    ser_load = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R11 not before third edge", disp_on, 1);
    @(negedge clk); check("R11 at third edge", disp_on, 0);
    wait_cyc(6); ser_load = 0; wait_cyc(8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule